// File: doc/BRIEF.md
# Dashboard 12-Hour Timekeeping Core

This core keeps the time of day for a vehicle dashboard clock. A fast oscillator clock is divided by a power of two down to a reference tick stream, 1024 Hz by default from a 4.194304 MHz source, and that reference is also driven out as a square wave. A strap input can replace the divider with an external reference of the same rate. A second stage counts reference ticks into whole seconds. It also drives a colon indicator that is high for the first half of every second. Seconds, minutes and hours are held in binary, and hours run 1 to 12.

Three debounced, synchronous driver controls set the time. One advances the hour and one advances the minute; each steps once on press and repeats at half-second intervals while held. The third rounds the time to the nearest whole minute. All three act only while the display-enable input is high. An asynchronous clear puts the time at 12:00:00. Every control is active high, so a pulled-down pin is inactive. Segment decoding and debouncing are outside the core.

Top module: `dashclock_core`

## Requirements
- R1: While `clr` is high, and right after it falls, the time reads hours 12, minutes 0, seconds 0, and `colon` is 1.
- R2: With `use_ext` low, one reference tick occurs every 2^DIV_LOG2 clock cycles. `ref_out` is 0 for the first half of each such period and 1 for the second half, and the tick falls on the last cycle of the period.
- R3: With `use_ext` high, `ext_ref` passes through two synchronizing flops. Each rising edge at the second flop makes one reference tick, and `ref_out` shows the second flop's value.
- R4: `seconds` advances by one every TICKS_PER_SEC reference ticks. `colon` is 1 while fewer than TICKS_PER_SEC/2 ticks of the current second have elapsed, and 0 otherwise.
- R5: In free running, seconds 59 wraps to 0 and adds a minute. Minutes 59 wraps to 0 and adds an hour. Hours 12 goes to 1.
- R6: A rising edge of the gated minute control adds one to minutes, wrapping 59 to 0 without touching hours, and sets seconds to 0.
- R7: A rising edge of the gated hour control adds one to hours, 12 going to 1, and leaves minutes and seconds unchanged.
- R8: While a gated adjust control stays high, its field steps again after every REPEAT_TICKS reference ticks, counted from the press.
- R9: A rising edge of the gated round control sets seconds to 0. If seconds were 30 or more, it also adds a minute, carrying into hours as in free running.
- R10: While `show_en` is low, the three controls have no effect. A control already high when `show_en` rises counts as a new press.
- R11: In one cycle, a round request overrides both adjust steps. Any round or adjust step absorbs a seconds tick that falls in the same cycle, and with no tick and no request the time holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| clr | input | 1 | Asynchronous clear, active high |
| use_ext | input | 1 | Strap: 1 selects the external reference |
| ext_ref | input | 1 | External reference clock, sampled by `clk` |
| show_en | input | 1 | Display enable; 0 blanks and locks the controls |
| hr_adj | input | 1 | Hour advance control |
| min_adj | input | 1 | Minute advance control |
| snap_req | input | 1 | Round to the nearest minute |
| ref_out | output | 1 | Reference square wave |
| colon | output | 1 | Colon indicator, 1 Hz |
| hours | output | 4 | Hours, 1 to 12 |
| minutes | output | 6 | Minutes, 0 to 59 |
| seconds | output | 6 | Seconds, 0 to 59 |

## Verification
Control inputs change on the falling clock edge. A press is registered at the next rising edge, and its effect on the time fields shows right after that edge, one cycle after the stimulus. Seconds ticks, repeat steps and `colon` follow the divider state with no added delay. External-reference ticks appear two clocks after an `ext_ref` edge, because of the synchronizer. The bench runs a behavioural model on the same rising edges and compares every output at each falling edge, half a period after all results are due. Directed checks at the corner cases sample at those same falling edges.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
  localparam int HOUR_W = 4;
  localparam int MS_W   = 6;

  function automatic logic [HOUR_W-1:0] next_hour(input logic [HOUR_W-1:0] h);
    return (h == 4'd12) ? 4'd1 : h + 4'd1;
  endfunction

  function automatic logic [MS_W-1:0] next_sixty(input logic [MS_W-1:0] v);
    return (v == 6'd59) ? 6'd0 : v + 6'd1;
  endfunction
endpackage

// File: rtl/dclk_refgen.sv
module dclk_refgen #(
  parameter int DIV_LOG2 = 12
) (
  input  logic clk,
  input  logic clr,
  input  logic use_ext,
  input  logic ext_ref,
  output logic tick,
  output logic ref_out
);
  logic [DIV_LOG2-1:0] div_cnt;
  logic [2:0]          sync_q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      div_cnt <= '0;
      sync_q  <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      sync_q  <= {sync_q[1:0], ext_ref};
    end
  end

  assign tick    = use_ext ? (sync_q[1] & ~sync_q[2]) : (&div_cnt);
  assign ref_out = use_ext ? sync_q[1] : div_cnt[DIV_LOG2-1];

  // After an internal tick the divider restarts in its low half.
  assert_divwrap_R2: assert property (@(posedge clk) disable iff (clr)
    (!use_ext && tick) |=> (use_ext || !ref_out));
  // An external edge yields a single-cycle tick.
  assert_extpulse_R3: assert property (@(posedge clk) disable iff (clr)
    (use_ext && tick) |=> (!use_ext || !tick));
endmodule

// File: rtl/dclk_secgen.sv
module dclk_secgen #(
  parameter int TICKS_PER_SEC = 1024
) (
  input  logic clk,
  input  logic clr,
  input  logic tick,
  output logic sec_pulse,
  output logic colon
);
  localparam int FW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [FW-1:0] LAST = FW'(TICKS_PER_SEC - 1);
  localparam logic [FW-1:0] HALF = FW'(TICKS_PER_SEC / 2);

  logic [FW-1:0] frac;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) frac <= '0;
    else if (tick) frac <= (frac == LAST) ? '0 : frac + 1'b1;
  end

  assign sec_pulse = tick && (frac == LAST);
  assign colon     = (frac < HALF);

  assert_colon_new_sec_R4: assert property (@(posedge clk) disable iff (clr)
    sec_pulse |=> colon);
endmodule

// File: rtl/dclk_stepper.sv
module dclk_stepper #(
  parameter int REPEAT_TICKS = 512
) (
  input  logic clk,
  input  logic clr,
  input  logic req,
  input  logic tick,
  output logic step
);
  localparam int RW = (REPEAT_TICKS > 1) ? $clog2(REPEAT_TICKS) : 1;
  localparam logic [RW-1:0] RLAST = RW'(REPEAT_TICKS - 1);

  logic          prev;
  logic [RW-1:0] rpt;
  logic          rise;

  assign rise = req & ~prev;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      prev <= 1'b0;
      rpt  <= '0;
    end else begin
      prev <= req;
      if (!req || rise) rpt <= '0;
      else if (tick)    rpt <= (rpt == RLAST) ? '0 : rpt + 1'b1;
    end
  end

  assign step = rise | (req & prev & tick & (rpt == RLAST));

  assert_no_step_idle_R10: assert property (@(posedge clk) disable iff (clr)
    !req |-> !step);
endmodule

// File: rtl/dclk_timekeep.sv
module dclk_timekeep
  import dclk_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              sec_pulse,
  input  logic              hr_step,
  input  logic              min_step,
  input  logic              snap_step,
  output logic [HOUR_W-1:0] hours,
  output logic [MS_W-1:0]   minutes,
  output logic [MS_W-1:0]   seconds
);
  logic [HOUR_W-1:0] h_n;
  logic [MS_W-1:0]   m_n, s_n;

  always_comb begin
    h_n = hours;
    m_n = minutes;
    s_n = seconds;
    if (snap_step) begin
      s_n = '0;
      if (seconds >= 6'd30) begin
        m_n = next_sixty(minutes);
        if (minutes == 6'd59) h_n = next_hour(hours);
      end
    end else if (hr_step || min_step) begin
      if (hr_step) h_n = next_hour(hours);
      if (min_step) begin
        m_n = next_sixty(minutes);
        s_n = '0;
      end
    end else if (sec_pulse) begin
      s_n = next_sixty(seconds);
      if (seconds == 6'd59) begin
        m_n = next_sixty(minutes);
        if (minutes == 6'd59) h_n = next_hour(hours);
      end
    end
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      hours   <= 4'd12;
      minutes <= '0;
      seconds <= '0;
    end else begin
      hours   <= h_n;
      minutes <= m_n;
      seconds <= s_n;
    end
  end

  assert_field_range_R5: assert property (@(posedge clk) disable iff (clr)
    (hours >= 4'd1) && (hours <= 4'd12) && (minutes < 6'd60) && (seconds < 6'd60));
  assert_min_clears_sec_R6: assert property (@(posedge clk) disable iff (clr)
    (min_step && !snap_step) |=> (seconds == 6'd0));
  assert_hour_roll_R7: assert property (@(posedge clk) disable iff (clr)
    (hr_step && !snap_step && hours == 4'd12) |=> (hours == 4'd1));
  assert_snap_zero_R9: assert property (@(posedge clk) disable iff (clr)
    snap_step |=> (seconds == 6'd0));
  assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (clr)
    !(snap_step || hr_step || min_step || sec_pulse) |=> $stable({hours, minutes, seconds}));
endmodule

// File: rtl/dashclock_core.sv
module dashclock_core
  import dclk_pkg::*;
#(
  parameter int DIV_LOG2      = 12,
  parameter int TICKS_PER_SEC = 1024,
  parameter int REPEAT_TICKS  = TICKS_PER_SEC / 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              use_ext,
  input  logic              ext_ref,
  input  logic              show_en,
  input  logic              hr_adj,
  input  logic              min_adj,
  input  logic              snap_req,
  output logic              ref_out,
  output logic              colon,
  output logic [HOUR_W-1:0] hours,
  output logic [MS_W-1:0]   minutes,
  output logic [MS_W-1:0]   seconds
);
  logic tick, sec_pulse;
  logic hr_step, min_step, snap_step;
  logic snap_gated, snap_prev;
  logic [1:0] adj_req, adj_step;

  dclk_refgen #(.DIV_LOG2(DIV_LOG2)) u_ref (
    .clk(clk), .clr(clr), .use_ext(use_ext), .ext_ref(ext_ref),
    .tick(tick), .ref_out(ref_out)
  );

  dclk_secgen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_sec (
    .clk(clk), .clr(clr), .tick(tick), .sec_pulse(sec_pulse), .colon(colon)
  );

  assign adj_req = {hr_adj & show_en, min_adj & show_en};

  for (genvar g = 0; g < 2; g++) begin : g_adj
    dclk_stepper #(.REPEAT_TICKS(REPEAT_TICKS)) u_step (
      .clk(clk), .clr(clr), .req(adj_req[g]), .tick(tick), .step(adj_step[g])
    );
  end

  assign min_step = adj_step[0];
  assign hr_step  = adj_step[1];

  assign snap_gated = snap_req & show_en;
  always_ff @(posedge clk or posedge clr) begin
    if (clr) snap_prev <= 1'b0;
    else     snap_prev <= snap_gated;
  end
  assign snap_step = snap_gated & ~snap_prev;

  dclk_timekeep u_time (
    .clk(clk), .clr(clr), .sec_pulse(sec_pulse),
    .hr_step(hr_step), .min_step(min_step), .snap_step(snap_step),
    .hours(hours), .minutes(minutes), .seconds(seconds)
  );

  assert_blank_lock_R10: assert property (@(posedge clk) disable iff (clr)
    !show_en |-> !(hr_step || min_step || snap_step));
endmodule

// File: tb/dashclock_core_test.sv
module dashclock_core_test;
  localparam int DL   = 2;
  localparam int DIVN = 1 << DL;
  localparam int TPS  = 8;
  localparam int RPT  = 4;
  localparam int SEC  = DIVN * TPS;

  logic clk = 0, clr = 1, use_ext = 0, ext_ref = 0, show_en = 1;
  logic hr_adj = 0, min_adj = 0, snap_req = 0;
  logic ref_out, colon;
  logic [3:0] hours;
  logic [5:0] minutes, seconds;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dashclock_core #(.DIV_LOG2(DL), .TICKS_PER_SEC(TPS), .REPEAT_TICKS(RPT)) uut (
    .clk(clk), .clr(clr), .use_ext(use_ext), .ext_ref(ext_ref), .show_en(show_en),
    .hr_adj(hr_adj), .min_adj(min_adj), .snap_req(snap_req),
    .ref_out(ref_out), .colon(colon), .hours(hours), .minutes(minutes), .seconds(seconds)
  );

  // Behavioural reference model
  int m_cnt, m_s0, m_s1, m_s2, m_frac, m_ph, m_pm, m_ps, m_rh, m_rm, mH, mM, mS;

  task automatic carry_min();
    if (mM == 59) begin mM = 0; mH = mH % 12 + 1; end
    else mM = mM + 1;
  endtask

  always @(posedge clk or posedge clr) begin
    if (clr) begin
      m_cnt = 0; m_s0 = 0; m_s1 = 0; m_s2 = 0; m_frac = 0;
      m_ph = 0; m_pm = 0; m_ps = 0; m_rh = 0; m_rm = 0;
      mH = 12; mM = 0; mS = 0;
    end else begin
      int tk, eh, em, es, hst, mst, sst, sp;
      tk  = use_ext ? (m_s1 && !m_s2) : (m_cnt == DIVN - 1);
      eh  = hr_adj && show_en;
      em  = min_adj && show_en;
      es  = snap_req && show_en;
      sp  = tk && (m_frac == TPS - 1);
      hst = (eh && !m_ph) || (eh && m_ph && tk && m_rh == RPT - 1);
      mst = (em && !m_pm) || (em && m_pm && tk && m_rm == RPT - 1);
      sst = es && !m_ps;
      if (!eh || !m_ph) m_rh = 0; else if (tk) m_rh = (m_rh + 1) % RPT;
      if (!em || !m_pm) m_rm = 0; else if (tk) m_rm = (m_rm + 1) % RPT;
      if (sst) begin
        if (mS >= 30) carry_min();
        mS = 0;
      end else if (hst || mst) begin
        if (hst) mH = mH % 12 + 1;
        if (mst) begin mM = (mM + 1) % 60; mS = 0; end
      end else if (sp) begin
        if (mS == 59) begin mS = 0; carry_min(); end
        else mS = mS + 1;
      end
      if (tk) m_frac = (m_frac + 1) % TPS;
      m_ph = eh; m_pm = em; m_ps = es;
      m_s2 = m_s1; m_s1 = m_s0; m_s0 = ext_ref;
      m_cnt = (m_cnt + 1) % DIVN;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int exp_ref;
      exp_ref = use_ext ? m_s1 : ((m_cnt >= DIVN / 2) ? 1 : 0);
      chk("R5 hours", hours, mH);
      chk("R5 minutes", minutes, mM);
      chk("R4 seconds", seconds, mS);
      chk("R4 colon", colon, (m_frac < TPS / 2) ? 1 : 0);
      chk(use_ext ? "R3 ref_out" : "R2 ref_out", ref_out, exp_ref);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tap(input int which);
    @(negedge clk);
    if (which == 0) hr_adj = 1; else if (which == 1) min_adj = 1; else snap_req = 1;
    @(negedge clk);
    hr_adj = 0; min_adj = 0; snap_req = 0;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h0, m0;
    wait_cyc(3);
    chk("R1 hours in clear", hours, 12);
    chk("R1 seconds in clear", seconds, 0);
    clr = 0;
    wait_cyc(1);
    chk("R1 colon after clear", colon, 1);
    chk("R1 minutes after clear", minutes, 0);

    // R4/R5: free running for 61 seconds
    wait_cyc(61 * SEC - 1);
    chk("R4 seconds after 61s", seconds, 1);
    chk("R5 minute carry", minutes, 1);

    // R6: single press and wrap without hour carry
    tap(1);
    chk("R6 minute step", minutes, 2);
    chk("R6 seconds cleared", seconds, 0);
    for (int i = 0; i < 70 && minutes != 59; i++) tap(1);
    h0 = hours;
    tap(1);
    chk("R6 minute wrap", minutes, 0);
    chk("R6 no hour carry", hours, h0);

    // R7: hour roll 12 -> 1, minutes untouched
    for (int i = 0; i < 14 && hours != 12; i++) tap(0);
    m0 = minutes;
    tap(0);
    chk("R7 hour roll", hours, 1);
    chk("R7 minutes kept", minutes, m0);

    // R8: auto-repeat while held
    m0 = minutes;
    @(negedge clk); min_adj = 1;
    wait_cyc(50);
    min_adj = 0;
    wait_cyc(1);
    chk("R8 repeat steps", minutes, (m0 + 4) % 60);

    // R9: round down, then round up with carry into hours
    tap(1);
    m0 = minutes;
    wait_cyc(10 * SEC);
    tap(2);
    chk("R9 round down minute", minutes, m0);
    chk("R9 round down seconds", seconds, 0);
    for (int i = 0; i < 70 && minutes != 59; i++) tap(1);
    h0 = hours;
    wait_cyc(35 * SEC);
    tap(2);
    chk("R9 round up minute", minutes, 0);
    chk("R9 round up hour", hours, h0 % 12 + 1);

    // R10: blanked controls are ignored
    h0 = hours; m0 = minutes;
    show_en = 0;
    tap(0); tap(1); tap(2);
    chk("R10 blanked hour", hours, h0);
    chk("R10 blanked minute", minutes, m0);
    @(negedge clk); min_adj = 1;
    wait_cyc(2);
    chk("R10 held while blanked", minutes, m0);
    show_en = 1;
    wait_cyc(1);
    min_adj = 0;
    wait_cyc(1);
    chk("R10 press on enable", minutes, (m0 + 1) % 60);

    // R11: round wins over a same-cycle minute step
    wait_cyc(5 * SEC);
    m0 = minutes;
    @(negedge clk); snap_req = 1; min_adj = 1;
    @(negedge clk); snap_req = 0; min_adj = 0;
    @(negedge clk);
    chk("R11 round overrides step", minutes, m0);
    chk("R11 seconds zero", seconds, 0);

    // R3: external reference drives the count
    use_ext = 1;
    for (int i = 0; i < 12 * TPS; i++) begin
      @(negedge clk); ext_ref = 1;
      wait_cyc(3); ext_ref = 0;
      wait_cyc(2);
    end
    wait_cyc(4);
    chk("R3 external seconds", seconds, mS);
    chk("R3 external advanced", (seconds >= 11) ? 1 : 0, 1);

    // R1: asynchronous clear mid-run
    use_ext = 0;
    @(negedge clk); #3 clr = 1;
    #2;
    chk("R1 async hours", hours, 12);
    chk("R1 async minutes", minutes, 0);
    @(negedge clk); clr = 0;
    wait_cyc(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule